// File: doc/BRIEF.md
# Configuration Record Chain Walker

This block reads a chain of self-sized configuration records out of a byte-wide memory that has a synchronous read port with one cycle of latency. A pulse on `start` loads a base address. The walker then fetches each record and splits its payload into a key string and a value string. It presents each finished pair on an output port guarded by a valid/ready handshake, together with a small code that classifies the key against four known names.

Each record begins with a 32-bit length word, stored least significant byte first. The length counts the 4-byte header plus the payload. The key is the run of payload bytes before the first zero byte. The value is every byte after that zero, and any later zero bytes in it are kept as data. The next record starts right after the current one. The walk ends when the block reads an all-ones length (erased memory), finds an empty key, or sees a length too small to hold its own header. After that the block raises `done` and holds it.

The host uses the block once after power-up to extract settings such as a network prefix, a hardware address, a broker address and a device label. Turning the value text into numbers is left to whatever consumes the output port.

Top module: `cfg_record_walker`

## Requirements
- R1: A `start` pulse loads `base_addr`, clears `done`, `overflow` and `malformed`, and in the following cycle the block issues a read (`mem_rd_en`=1) at `base_addr`.
- R2: The length word is assembled from four consecutive byte reads, least significant byte first. It covers the 4 header bytes plus the payload, and the next record starts at record address plus length.
- R3: Payload bytes before the first zero byte form the key. All bytes after that zero, up to the record end, form the value, and later zero bytes are kept. On `out_key` and `out_val`, character i sits in bits [8i+7:8i], and unused byte lanes read zero. A payload without any zero byte yields an empty value.
- R4: `out_kind` is 1 for key "CIDR", 2 for "MAC", 3 for "BrokerIP", 4 for "Name", and 0 for any other key. An unknown key is presented like any other record and the walk continues.
- R5: Every record with a non-empty key is presented once, in chain order. While `out_valid` is high and `out_ready` is low, `out_valid`, the key, the value, both lengths and `out_kind` hold steady.
- R6: A length word of 0xFFFFFFFF ends the walk: `done` rises, no record is presented and `malformed` stays low.
- R7: A record whose key is empty (first payload byte zero, or length exactly 4) ends the walk without being presented.
- R8: Key bytes beyond KEY_MAX and value bytes beyond VAL_MAX are dropped, `overflow` is set and stays set until the next `start`, and the walk carries on at the next record.
- R9: A length below 4 sets `malformed` and ends the walk with `done` high.
- R10: Once high, `done` stays high until the next `start`. While `done` is high, `out_valid` and `mem_rd_en` are low. At most one memory read is in flight, so `mem_rd_en` is never high in two consecutive cycles without an intervening `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a walk at `base_addr` |
| base_addr | input | AW | Address of the first record |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory byte address |
| mem_rd_data | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| out_valid | output | 1 | A parsed record is on the output |
| out_ready | input | 1 | Consumer accepts the record |
| out_key | output | KEY_MAX*8 | Key characters, first character in the low byte |
| out_key_len | output | clog2(KEY_MAX+1) | Number of stored key characters |
| out_val | output | VAL_MAX*8 | Value bytes, first byte in the low byte |
| out_val_len | output | clog2(VAL_MAX+1) | Number of stored value bytes |
| out_kind | output | 3 | Key class code |
| done | output | 1 | Walk finished |
| overflow | output | 1 | Sticky: a key or value was truncated |
| malformed | output | 1 | A length below 4 stopped the walk |

## Verification
The interesting collision is between the output handshake and the start of the next record. In the cycle a record is accepted, the buffers clear, the record pointer jumps to the record end, and the length fetch of the next record is armed, all together. The bench drives `out_ready` at random, so a record is sometimes accepted in the first cycle it is offered and sometimes only after several stalls. Those stalls must leave the outputs frozen. Every accepted record is compared field by field against a behavioural walk of the same memory image, and a dropped, repeated or corrupted record shows up there, as does a record stepped over by a wrong length.

// File: rtl/cfgwalk_pkg.sv
// Shared types for the configuration record walker.
package cfgwalk_pkg;
    // Class code reported for each presented key.
    typedef enum logic [2:0] {
        KIND_OTHER  = 3'd0,
        KIND_PREFIX = 3'd1,
        KIND_HWADDR = 3'd2,
        KIND_BROKER = 3'd3,
        KIND_LABEL  = 3'd4
    } key_kind_e;

    // Walker sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEN,
        ST_PAY,
        ST_EMIT,
        ST_DONE
    } walk_st_e;
endpackage

// File: rtl/cfgwalk_bytebuf.sv
// Byte accumulator: appends bytes in arrival order, first byte in the low lane.
// Assumes: clr and push are never useful together (clr wins). Bytes pushed
// beyond DEPTH are discarded and reported on drop_o for that cycle.
module cfgwalk_bytebuf #(
    parameter  int DEPTH = 32,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               push,
    input  logic [7:0]         din,
    output logic [DEPTH*8-1:0] data_o,
    output logic [LW-1:0]      len_o,
    output logic               drop_o
);
    logic [LW-1:0] fill_q;
    logic          room;

    assign room   = (fill_q < LW'(DEPTH));
    assign drop_o = push && !room;
    assign len_o  = fill_q;

    // Fill counter: counts stored bytes, saturates at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            fill_q <= '0;
        else if (push && room)
            fill_q <= fill_q + 1'b1;
    end

    // One register per byte lane, written when the fill pointer reaches it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                data_o[8*i +: 8] <= 8'h00;
            else if (push && fill_q == LW'(i))
                data_o[8*i +: 8] <= din;
        end
    end
endmodule

// File: rtl/cfgwalk_keyclass.sv
// Key classifier: matches the stored key against the four known names.
// Assumes: key bytes are packed first character in the low lane, and the
// key buffer is at least 8 characters wide (the longest known name).
module cfgwalk_keyclass #(
    parameter int KLW = 6
) (
    input  logic [63:0]    key_i,
    input  logic [KLW-1:0] len_i,
    output logic [2:0]     kind_o
);
    import cfgwalk_pkg::*;

    // Pure compare of length and leading characters against each name.
    always_comb begin
        kind_o = KIND_OTHER;
        if (len_i == KLW'(4) && key_i[31:0] == {"R", "D", "I", "C"})
            kind_o = KIND_PREFIX;
        else if (len_i == KLW'(3) && key_i[23:0] == {"C", "A", "M"})
            kind_o = KIND_HWADDR;
        else if (len_i == KLW'(8) &&
                 key_i[63:0] == {"P", "I", "r", "e", "k", "o", "r", "B"})
            kind_o = KIND_BROKER;
        else if (len_i == KLW'(4) && key_i[31:0] == {"e", "m", "a", "N"})
            kind_o = KIND_LABEL;
    end
endmodule

// File: rtl/cfg_record_walker.sv
// Configuration record walker (top).
// Walks length-prefixed key/value records from base_addr, one byte read in
// flight at a time (read issued in one cycle, data used in the next).
// Assumes: memory read latency is exactly one cycle; AW <= 32; KEY_MAX >= 8.
module cfg_record_walker #(
    parameter  int AW      = 16,
    parameter  int KEY_MAX = 32,
    parameter  int VAL_MAX = 64,
    localparam int KLW     = $clog2(KEY_MAX + 1),
    localparam int VLW     = $clog2(VAL_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AW-1:0]        base_addr,
    output logic                 mem_rd_en,
    output logic [AW-1:0]        mem_addr,
    input  logic [7:0]           mem_rd_data,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [KEY_MAX*8-1:0] out_key,
    output logic [KLW-1:0]       out_key_len,
    output logic [VAL_MAX*8-1:0] out_val,
    output logic [VLW-1:0]       out_val_len,
    output logic [2:0]           out_kind,
    output logic                 done,
    output logic                 overflow,
    output logic                 malformed
);
    import cfgwalk_pkg::*;

    walk_st_e      st_q;
    logic [AW-1:0] rec_q, cur_q, end_q;
    logic [23:0]   len_lo_q;
    logic [1:0]    idx_q;
    logic          pend_q, in_val_q, ovf_q, bad_q;
    logic [31:0]   len_full;
    logic          key_push, val_push, key_drop, val_drop, buf_clr;

    assign len_full  = {mem_rd_data, len_lo_q};
    assign mem_rd_en = !pend_q &&
                       (st_q == ST_LEN || (st_q == ST_PAY && cur_q != end_q));
    assign mem_addr  = cur_q;

    assign key_push  = (st_q == ST_PAY) && pend_q && !in_val_q && (mem_rd_data != 8'h00);
    assign val_push  = (st_q == ST_PAY) && pend_q && in_val_q;
    assign buf_clr   = start || (st_q == ST_EMIT && out_ready);

    assign out_valid = (st_q == ST_EMIT);
    assign done      = (st_q == ST_DONE);
    assign overflow  = ovf_q;
    assign malformed = bad_q;

    cfgwalk_bytebuf #(.DEPTH(KEY_MAX)) u_key_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .push(key_push),
        .din(mem_rd_data), .data_o(out_key), .len_o(out_key_len), .drop_o(key_drop)
    );

    cfgwalk_bytebuf #(.DEPTH(VAL_MAX)) u_val_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .push(val_push),
        .din(mem_rd_data), .data_o(out_val), .len_o(out_val_len), .drop_o(val_drop)
    );

    cfgwalk_keyclass #(.KLW(KLW)) u_class (
        .key_i(out_key[63:0]), .len_i(out_key_len), .kind_o(out_kind)
    );

    // Walk sequencer: header fetch, payload split, hand-off, termination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            rec_q    <= '0;
            cur_q    <= '0;
            end_q    <= '0;
            len_lo_q <= '0;
            idx_q    <= '0;
            pend_q   <= 1'b0;
            in_val_q <= 1'b0;
            ovf_q    <= 1'b0;
            bad_q    <= 1'b0;
        end else if (start) begin
            st_q     <= ST_LEN;
            rec_q    <= base_addr;
            cur_q    <= base_addr;
            idx_q    <= '0;
            pend_q   <= 1'b0;
            in_val_q <= 1'b0;
            ovf_q    <= 1'b0;
            bad_q    <= 1'b0;
        end else begin
            if (key_drop || val_drop)
                ovf_q <= 1'b1;
            unique case (st_q)
                ST_LEN: begin
                    if (!pend_q) begin
                        pend_q <= 1'b1;
                    end else begin
                        pend_q <= 1'b0;
                        cur_q  <= cur_q + 1'b1;
                        idx_q  <= idx_q + 1'b1;
                        if (idx_q != 2'd3) begin
                            len_lo_q[8*idx_q +: 8] <= mem_rd_data;
                        end else if (len_full == 32'hFFFF_FFFF) begin
                            st_q <= ST_DONE;
                        end else if (len_full < 32'd4) begin
                            bad_q <= 1'b1;
                            st_q  <= ST_DONE;
                        end else begin
                            end_q    <= rec_q + len_full[AW-1:0];
                            in_val_q <= 1'b0;
                            st_q     <= ST_PAY;
                        end
                    end
                end
                ST_PAY: begin
                    if (pend_q) begin
                        pend_q <= 1'b0;
                        cur_q  <= cur_q + 1'b1;
                        if (!in_val_q && mem_rd_data == 8'h00)
                            in_val_q <= 1'b1;
                    end else if (cur_q == end_q) begin
                        st_q <= (out_key_len == '0) ? ST_DONE : ST_EMIT;
                    end else begin
                        pend_q <= 1'b1;
                    end
                end
                ST_EMIT: begin
                    if (out_ready) begin
                        rec_q <= end_q;
                        cur_q <= end_q;
                        idx_q <= '0;
                        st_q  <= ST_LEN;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_record_walker_chk.sv
// Property checker for the configuration record walker, bound to the top.
module cfg_record_walker_chk #(
    parameter  int AW      = 16,
    parameter  int KEY_MAX = 32,
    parameter  int VAL_MAX = 64,
    localparam int KLW     = $clog2(KEY_MAX + 1),
    localparam int VLW     = $clog2(VAL_MAX + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [AW-1:0]        base_addr,
    input logic                 mem_rd_en,
    input logic [AW-1:0]        mem_addr,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [KEY_MAX*8-1:0] out_key,
    input logic [KLW-1:0]       out_key_len,
    input logic [VAL_MAX*8-1:0] out_val,
    input logic [VLW-1:0]       out_val_len,
    input logic [2:0]           out_kind,
    input logic                 done,
    input logic                 overflow,
    input logic                 malformed
);
    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> mem_rd_en && mem_addr == $past(base_addr) && !done && !malformed && !overflow); // R1

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !start |=> out_valid && $stable(out_key) &&
        $stable(out_val) && $stable(out_key_len) && $stable(out_val_len) && $stable(out_kind)); // R5

    AST_KEY_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_key_len != '0 && out_key_len <= KLW'(KEY_MAX)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !start |=> overflow); // R8

    AST_BAD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        malformed |-> done); // R9

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done); // R10

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid && !mem_rd_en); // R10

    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en && !start |=> !mem_rd_en); // R10
endmodule

bind cfg_record_walker cfg_record_walker_chk #(
    .AW(AW), .KEY_MAX(KEY_MAX), .VAL_MAX(VAL_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_key(out_key), .out_key_len(out_key_len),
    .out_val(out_val), .out_val_len(out_val_len), .out_kind(out_kind),
    .done(done), .overflow(overflow), .malformed(malformed)
);

// File: tb/cfg_record_walker_bench.sv
module cfg_record_walker_bench;
    localparam int AW      = 16;
    localparam int KEY_MAX = 32;
    localparam int VAL_MAX = 64;
    localparam int KLW     = $clog2(KEY_MAX + 1);
    localparam int VLW     = $clog2(VAL_MAX + 1);
    localparam int MSZ     = 512;

    typedef logic [7:0] bq_t[$];
    typedef struct {
        logic [KEY_MAX*8-1:0] key;
        int                   klen;
        logic [VAL_MAX*8-1:0] val;
        int                   vlen;
        int                   kind;
    } rec_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [AW-1:0]        base_addr = '0;
    logic                 mem_rd_en;
    logic [AW-1:0]        mem_addr;
    logic [7:0]           mem_rd_data = 8'h00;
    logic                 out_valid;
    logic                 out_ready = 1'b0;
    logic [KEY_MAX*8-1:0] out_key;
    logic [KLW-1:0]       out_key_len;
    logic [VAL_MAX*8-1:0] out_val;
    logic [VLW-1:0]       out_val_len;
    logic [2:0]           out_kind;
    logic                 done, overflow, malformed;

    logic [7:0] mem [0:MSZ-1];
    rec_t       exp_q[$];
    bit         exp_ovf, exp_bad;
    int         n_checks = 0;
    int         n_errors = 0;

    always #2 clk = ~clk;

    cfg_record_walker #(.AW(AW), .KEY_MAX(KEY_MAX), .VAL_MAX(VAL_MAX)) u_cfg_record_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key),
        .out_key_len(out_key_len), .out_val(out_val), .out_val_len(out_val_len),
        .out_kind(out_kind), .done(done), .overflow(overflow), .malformed(malformed)
    );

    function automatic logic [7:0] rd(int a);
        return (a >= 0 && a < MSZ) ? mem[a] : 8'hFF;
    endfunction

    // Memory with one cycle of read latency.
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= rd(int'(mem_addr));

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bq_t s2q(string s);
        bq_t q;
        for (int i = 0; i < s.len(); i++) q.push_back(s[i]);
        return q;
    endfunction

    function automatic bit qeq(bq_t q, string s);
        if (q.size() != s.len()) return 0;
        for (int i = 0; i < s.len(); i++) if (q[i] != s[i]) return 0;
        return 1;
    endfunction

    task automatic put_len(input int a, input logic [31:0] len);
        for (int i = 0; i < 4; i++) mem[a+i] = len[8*i +: 8];
    endtask

    task automatic put_rec(inout int a, input string k, input bq_t v);
        int n = 4 + k.len() + 1 + v.size();
        put_len(a, n);
        for (int i = 0; i < k.len(); i++) mem[a+4+i] = k[i];
        mem[a+4+k.len()] = 8'h00;
        for (int i = 0; i < v.size(); i++) mem[a+5+k.len()+i] = v[i];
        a += n;
    endtask

    // Behavioural walk of the memory image (R2, R3, R4, R6..R9).
    task automatic model_walk(input int base);
        int a = base;
        exp_q.delete();
        exp_ovf = 0;
        exp_bad = 0;
        for (int g = 0; g < 64; g++) begin
            logic [31:0] len = {rd(a+3), rd(a+2), rd(a+1), rd(a)};
            bq_t k, v;
            bit inv = 0;
            rec_t r;
            if (len == 32'hFFFF_FFFF) break;
            if (len < 4) begin exp_bad = 1; break; end
            for (int p = a + 4; p < a + int'(len); p++) begin
                logic [7:0] b = rd(p);
                if (inv) v.push_back(b);
                else if (b == 8'h00) inv = 1;
                else k.push_back(b);
            end
            if (k.size() == 0) break;
            r.key = '0; r.val = '0;
            r.klen = (k.size() > KEY_MAX) ? KEY_MAX : k.size();
            r.vlen = (v.size() > VAL_MAX) ? VAL_MAX : v.size();
            if (k.size() > KEY_MAX || v.size() > VAL_MAX) exp_ovf = 1;
            for (int i = 0; i < r.klen; i++) r.key[8*i +: 8] = k[i];
            for (int i = 0; i < r.vlen; i++) r.val[8*i +: 8] = v[i];
            r.kind = qeq(k, "CIDR") ? 1 : qeq(k, "MAC") ? 2 :
                     qeq(k, "BrokerIP") ? 3 : qeq(k, "Name") ? 4 : 0;
            exp_q.push_back(r);
            a += int'(len);
        end
    endtask

    // Run one walk, comparing the output port to the model on every clock.
    task automatic run_walk(input int base, input int ready_mode, input string tag);
        bit hold = 0;
        logic [KEY_MAX*8-1:0] hk;
        logic [VAL_MAX*8-1:0] hv;
        logic [2:0] hkind;
        int cyc = 0;
        model_walk(base);
        @(negedge clk);
        base_addr = AW'(base);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(mem_rd_en && mem_addr == AW'(base) && !done && !malformed && !overflow,
              "R1", {tag, " start loads base and clears flags"},
              {mem_rd_en, done, malformed, overflow, mem_addr}, {4'b1000, AW'(base)});
        while (!done && cyc < 5000) begin
            if (hold)
                check(out_valid && out_key == hk && out_val == hv && out_kind == hkind,
                      "R5", {tag, " stalled record held"}, out_key, hk);
            if (ready_mode == 0) out_ready = ($urandom_range(0, 3) != 0);
            else if (ready_mode == 1) out_ready = 1'b1;
            else out_ready = ($urandom_range(0, 3) == 0);
            if (out_valid && out_ready) begin
                hold = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R7", {tag, " unexpected record"}, out_key, '0);
                end else begin
                    rec_t r = exp_q.pop_front();
                    check(out_key == r.key, "R3", {tag, " key"}, out_key, r.key);
                    check(out_key_len == KLW'(r.klen), "R8", {tag, " key length"}, out_key_len, r.klen);
                    check(out_val == r.val, "R3", {tag, " value"}, out_val, r.val);
                    check(out_val_len == VLW'(r.vlen), "R8", {tag, " value length"}, out_val_len, r.vlen);
                    check(out_kind == 3'(r.kind), "R4", {tag, " kind"}, out_kind, r.kind);
                end
            end else begin
                hold = out_valid;
                hk = out_key; hv = out_val; hkind = out_kind;
            end
            @(negedge clk);
            cyc++;
        end
        check(done, "R10", {tag, " walk reached done"}, done, 1);
        check(exp_q.size() == 0, "R2", {tag, " all records presented"}, exp_q.size(), 0);
        check(overflow == exp_ovf, "R8", {tag, " overflow flag"}, overflow, exp_ovf);
        check(malformed == exp_bad, "R9", {tag, " malformed flag"}, malformed, exp_bad);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(done && !mem_rd_en && !out_valid, "R10", {tag, " done holds quietly"},
                  {done, mem_rd_en, out_valid}, 3'b100);
        end
    endtask

    initial begin
        #800000;
        check(0, "R10", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int a;
        for (int i = 0; i < MSZ; i++) mem[i] = 8'hFF;
        // Chain A at 0: known and unknown keys, embedded zero, empty value, no separator.
        a = 0;
        put_rec(a, "CIDR", s2q("10.0.0.2/24"));
        put_rec(a, "MAC", s2q("02:00:00:00:00:01"));
        put_rec(a, "Foo", '{8'h31, 8'h00, 8'h32});
        put_rec(a, "BrokerIP", s2q("10.0.0.1"));
        put_rec(a, "MACX", s2q("x"));
        put_rec(a, "Name", s2q("dds0"));
        put_rec(a, "CID", s2q("y"));
        put_rec(a, "Name", '{});
        put_len(a, 7); mem[a+4] = "a"; mem[a+5] = "b"; mem[a+6] = "c"; a += 7;
        // Chain B at 256: oversize key and value, then a header-only record.
        a = 256;
        begin
            string kl = "";
            bq_t vl;
            for (int i = 0; i < 40; i++) kl = {kl, "k"};
            for (int i = 0; i < 70; i++) vl.push_back(8'(i + 1));
            put_rec(a, kl, vl);
        end
        put_rec(a, "Name", s2q("n2"));
        put_len(a, 4); a += 4;
        put_rec(a, "MAC", s2q("zz"));
        // Chain C at 400: one record then an undersized length.
        a = 400;
        put_rec(a, "CIDR", s2q("1"));
        put_len(a, 2);
        // Chain D at 440: first payload byte zero.
        put_len(440, 6); mem[444] = 8'h00; mem[445] = "A";
        // Chain E at 480 is left erased.

        repeat (3) @(negedge clk);
        check(!out_valid && !done && !mem_rd_en && !overflow && !malformed, "R10",
              "reset state idle", {out_valid, done, mem_rd_en, overflow, malformed}, 0);
        rst_n = 1'b1;
        run_walk(0,   0, "chainA R2 R3 R4");
        run_walk(256, 1, "chainB R7 R8");
        run_walk(400, 2, "chainC R9");
        run_walk(440, 0, "chainD R7");
        run_walk(480, 1, "chainE R6");
        run_walk(0,   2, "chainA-again R5");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule